// File: doc/BRIEF.md
# Host-Mastered DMA Slave Port

This block lets an external host, acting as bus master, move data into or out of the device over an asynchronous memory-style bus. The bus has an active-low chip select, active-low read and write strobes, and one address line. Address 0 reaches a control word on writes and a status word on reads. Address 1 reaches the data path. Inside the device, data passes through an 8-entry by 16-bit FIFO to a plain valid/ready stream. Only one direction is active at a time, and a control bit selects it.

The host can use an 8-bit or a 16-bit data width, in either byte order. In 8-bit mode, two host bytes are packed into one FIFO entry. Two flow-control styles are offered. In the first, a ready/acknowledge output tells the host whether the next data access can be served. In the second, an interrupt output tells the host that a whole FIFO-depth burst can run without stalling. The host strobes are brought into the internal clock through a two-flop synchronizer. Each access takes effect at the strobe's deasserting edge. The port does nothing until an internal enable input is high.

Top module: `hostdma_port`

## Requirements
- R1: After reset, and while `cfg_en` is low, `hp_ack`, `hp_irq`, `dma_out_valid` and `dma_in_ready` are low. The FIFO is emptied and host accesses are ignored, including writes to the control word.
- R2: A write to address 0 loads the control word. Bit 0 is the direction (0 = host to device, 1 = device to host). Bit 1 selects 16-bit width (0 = 8-bit). Bit 2 selects big-endian order (0 = little-endian). Bit 3 selects interrupt mode. A read of address 0 returns a status word: bits 3:0 hold the control word, bits 7:4 hold the FIFO entry count and bit 8 holds the burst-ready flag.
- R3: An access takes effect only after its strobe has ended, passing through a two-flop synchronizer. A status read has no side effect.
- R4: In 16-bit mode with direction 0, each data write pushes one entry. In little-endian mode the entry is the host word unchanged. In big-endian mode the two bytes are swapped.
- R5: In 8-bit mode with direction 0, host bytes arrive on data bits 7:0, and every second byte pushes one entry. In little-endian mode the first byte becomes entry bits 7:0. In big-endian mode the first byte becomes bits 15:8. A lone first byte is not counted in the status.
- R6: In 16-bit mode with direction 1, a data read returns the head entry, byte-swapped in big-endian mode, and then pops it.
- R7: In 8-bit mode with direction 1, the first data read returns the first byte on bits 7:0 without popping: entry bits 7:0 in little-endian mode, bits 15:8 in big-endian mode. The second read returns the other byte and pops the entry. Bits 15:8 of the read data are 0.
- R8: In acknowledge mode, `hp_ack` is high only when the next data access can be served. For direction 0 that means the FIFO is not full; for direction 1 it means the FIFO is not empty. Data writes to a full FIFO are dropped.
- R9: In interrupt mode, `hp_irq` is high when a full 8-entry burst can run: for direction 0 when the FIFO is empty, for direction 1 when it is full. In this mode `hp_ack` stays high while the port is enabled.
- R10: A control write that changes the direction bit empties the FIFO.
- R11: Entries leave the FIFO in arrival order, and it holds at most 8 of them. The internal stream moves one entry on each clock edge where valid and ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Port enable from internal configuration |
| hp_cs_n | input | 1 | Host chip select, active low |
| hp_rd_n | input | 1 | Host read strobe, active low |
| hp_wr_n | input | 1 | Host write strobe, active low |
| hp_addr | input | 1 | 0 = control/status, 1 = data |
| hp_din | input | 16 | Host write data |
| hp_dout | output | 16 | Host read data, registered |
| hp_ack | output | 1 | Ready for the next data access |
| hp_irq | output | 1 | Full-depth burst can be served |
| dma_out_valid | output | 1 | Entry available toward the device |
| dma_out_ready | input | 1 | Device accepts the entry |
| dma_out_data | output | 16 | Entry toward the device |
| dma_in_valid | input | 1 | Device offers an entry |
| dma_in_ready | output | 1 | Port accepts the offered entry |
| dma_in_data | input | 16 | Entry from the device |

## Verification
Directed sequences run every pairing of width and byte order in both directions, using distinct byte values, so that a swapped or misplaced byte shows as a data mismatch. Filling the FIFO to eight entries and then writing a ninth separates correct full handling (ack low, ninth word dropped) from overflow or wrap errors. Flipping the direction with entries queued, and dropping the enable, shows whether the FIFO is flushed. Random bursts of one to eight words, with random width and endianness, are checked against a queue model to show that order is kept across many mode changes.

// File: rtl/hostdma_pkg.sv
package hostdma_pkg;
  localparam int HW = 16;

  typedef struct packed {
    logic irq_mode;
    logic big;
    logic wide;
    logic dir;
  } ctrl_t;

  function automatic logic [HW-1:0] swap16(input logic [HW-1:0] v);
    return {v[7:0], v[15:8]};
  endfunction
endpackage

// File: rtl/hostdma_sync.sv
module hostdma_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic level,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], async_in};
  end

  assign level = sh[STAGES-1];
  assign fall  = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/hostdma_fifo.sv
module hostdma_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               rdata,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= wp + 1'b1;
      if (pop_ok)  rp <= rp + 1'b1;
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/hostdma_port.sv
module hostdma_port
  import hostdma_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_en,
  input  logic          hp_cs_n,
  input  logic          hp_rd_n,
  input  logic          hp_wr_n,
  input  logic          hp_addr,
  input  logic [15:0]   hp_din,
  output logic [15:0]   hp_dout,
  output logic          hp_ack,
  output logic          hp_irq,
  output logic          dma_out_valid,
  input  logic          dma_out_ready,
  output logic [15:0]   dma_out_data,
  input  logic          dma_in_valid,
  output logic          dma_in_ready,
  input  logic [15:0]   dma_in_data
);
  localparam int CW = $clog2(DEPTH) + 1;
  localparam int SW = 4 + CW + 1;

  // strobe synchronization
  logic wr_act, rd_act, wr_lvl, rd_lvl, wr_end, rd_end;
  assign wr_act = ~hp_cs_n & ~hp_wr_n;
  assign rd_act = ~hp_cs_n & ~hp_rd_n;

  hostdma_sync #(.STAGES(SYNC_STAGES)) u_wsync (
    .clk(clk), .rst(rst), .async_in(wr_act), .level(wr_lvl), .fall(wr_end));
  hostdma_sync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk(clk), .rst(rst), .async_in(rd_act), .level(rd_lvl), .fall(rd_end));

  // capture of address/data while the strobe is held
  logic          lat_waddr, lat_raddr;
  logic [HW-1:0] lat_wdata;
  always_ff @(posedge clk) begin
    if (rst) begin
      lat_waddr <= 1'b0;
      lat_raddr <= 1'b0;
      lat_wdata <= '0;
    end else begin
      if (wr_act) begin
        lat_waddr <= hp_addr;
        lat_wdata <= hp_din;
      end
      if (rd_act) lat_raddr <= hp_addr;
    end
  end

  // control
  ctrl_t ctrl, new_ctrl;
  logic  en_q, ctrl_wr, data_wr, data_rd, flush;
  assign new_ctrl = ctrl_t'(lat_wdata[3:0]);
  assign ctrl_wr  = wr_end & cfg_en & ~lat_waddr;
  assign data_wr  = wr_end & cfg_en & lat_waddr & ~ctrl.dir;
  assign data_rd  = rd_end & cfg_en & lat_raddr & ctrl.dir;
  assign flush    = ~cfg_en | (ctrl_wr & (new_ctrl.dir != ctrl.dir));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      en_q <= 1'b0;
    end else begin
      en_q <= cfg_en;
      if (ctrl_wr) ctrl <= new_ctrl;
    end
  end

  // FIFO
  logic [HW-1:0] fifo_wdata, head;
  logic [CW-1:0] fifo_count;
  logic          fifo_push, fifo_pop, full, empty;
  logic          host_push, host_pop;

  hostdma_fifo #(.W(HW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(flush),
    .push(fifo_push), .wdata(fifo_wdata),
    .pop(fifo_pop), .rdata(head),
    .count(fifo_count), .full(full), .empty(empty));

  // host write packing
  logic          wpend;
  logic [7:0]    wbuf;
  logic [HW-1:0] in_word;
  always_comb begin
    if (ctrl.wide) in_word = ctrl.big ? swap16(lat_wdata) : lat_wdata;
    else           in_word = ctrl.big ? {wbuf, lat_wdata[7:0]} : {lat_wdata[7:0], wbuf};
  end
  assign host_push = data_wr & (ctrl.wide | wpend) & ~full;

  always_ff @(posedge clk) begin
    if (rst || ctrl_wr || !cfg_en) begin
      wpend <= 1'b0;
      wbuf  <= '0;
    end else if (data_wr && !ctrl.wide && !full) begin
      wpend <= ~wpend;
      if (!wpend) wbuf <= lat_wdata[7:0];
    end
  end

  // host read unpacking
  logic          rpend;
  logic [7:0]    first_b, second_b;
  logic [HW-1:0] view;
  assign first_b  = ctrl.big ? head[15:8] : head[7:0];
  assign second_b = ctrl.big ? head[7:0]  : head[15:8];
  assign view     = ctrl.wide ? (ctrl.big ? swap16(head) : head)
                              : {8'h00, (rpend ? second_b : first_b)};
  assign host_pop = data_rd & ~empty & (ctrl.wide | rpend);

  always_ff @(posedge clk) begin
    if (rst || ctrl_wr || !cfg_en) rpend <= 1'b0;
    else if (data_rd && !ctrl.wide && !empty) rpend <= ~rpend;
  end

  // internal stream side
  assign dma_out_valid = ~ctrl.dir & ~empty;
  assign dma_out_data  = head;
  assign dma_in_ready  = ctrl.dir & en_q & ~full;

  assign fifo_push  = ctrl.dir ? (dma_in_valid & dma_in_ready) : host_push;
  assign fifo_wdata = ctrl.dir ? dma_in_data : in_word;
  assign fifo_pop   = ctrl.dir ? host_pop : (dma_out_valid & dma_out_ready);

  // registered host outputs
  logic          burst;
  logic [HW-1:0] status;
  assign burst  = ctrl.dir ? full : empty;
  assign status = {{(HW-SW){1'b0}}, burst, fifo_count, ctrl};

  always_ff @(posedge clk) begin
    if (rst) begin
      hp_dout <= '0;
      hp_ack  <= 1'b0;
      hp_irq  <= 1'b0;
    end else begin
      hp_dout <= hp_addr ? view : status;
      hp_ack  <= cfg_en & (ctrl.irq_mode | (ctrl.dir ? ~empty : ~full));
      hp_irq  <= cfg_en & ctrl.irq_mode & burst;
    end
  end
endmodule

// File: rtl/hostdma_chk.sv
module hostdma_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_en,
  input logic          hp_ack,
  input logic          hp_irq,
  input logic          dma_out_valid,
  input logic          dma_in_ready,
  input logic          dir,
  input logic          irq_mode,
  input logic [CW-1:0] count
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R11
  AST_DIS_QUIET: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> (!hp_ack && !hp_irq && !dma_out_valid && !dma_in_ready)); // R1
  AST_ACK_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    hp_ack |-> $past(cfg_en)); // R8
  AST_DIR_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (dir != $past(dir)) |-> (count == '0)); // R10
  AST_IRQ_BURST: assert property (@(posedge clk) disable iff (rst)
    hp_irq |-> $past(irq_mode && (dir ? (count == CW'(DEPTH)) : (count == '0)))); // R9
endmodule

bind hostdma_port hostdma_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .cfg_en(cfg_en), .hp_ack(hp_ack), .hp_irq(hp_irq),
  .dma_out_valid(dma_out_valid), .dma_in_ready(dma_in_ready),
  .dir(ctrl.dir), .irq_mode(ctrl.irq_mode), .count(fifo_count));

// File: tb/tb_hostdma_port.sv
`timescale 1ns/1ps
module tb_hostdma_port;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, cfg_en, hp_cs_n, hp_rd_n, hp_wr_n, hp_addr;
  logic [15:0] hp_din, hp_dout, dma_out_data, dma_in_data;
  logic hp_ack, hp_irq, dma_out_valid, dma_out_ready, dma_in_valid, dma_in_ready;

  hostdma_port dut (.*);

  int checks = 0, errors = 0;
  logic [15:0] got[$];
  logic [15:0] exp_q[$];

  always @(negedge clk)
    if (!rst && dma_out_valid && dma_out_ready) got.push_back(dma_out_data);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sw(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction
  function automatic logic [15:0] cw(input bit dir, input bit wide, input bit big, input bit irq);
    return {12'h0, irq, big, wide, dir};
  endfunction
  function automatic logic [15:0] st(input logic [15:0] c, input int cnt, input bit burst);
    return {7'h0, burst, 4'(cnt), c[3:0]};
  endfunction

  task automatic hwrite(input logic a, input logic [15:0] d);
    @(negedge clk); hp_addr = a; hp_din = d; hp_cs_n = 0; hp_wr_n = 0;
    repeat (4) @(negedge clk);
    hp_cs_n = 1; hp_wr_n = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic hread(input logic a, output logic [15:0] d);
    @(negedge clk); hp_addr = a; hp_cs_n = 0; hp_rd_n = 0;
    repeat (4) @(negedge clk);
    d = hp_dout;
    hp_cs_n = 1; hp_rd_n = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic push_in(input logic [15:0] d);
    @(negedge clk);
    while (!dma_in_ready) @(negedge clk);
    dma_in_valid = 1; dma_in_data = d;
    @(negedge clk);
    dma_in_valid = 0;
  endtask

  task automatic drain_cmp(string req);
    dma_out_ready = 1;
    repeat (20) @(negedge clk);
    dma_out_ready = 0;
    chk({req, " count"}, got.size(), exp_q.size());
    while (got.size() > 0 && exp_q.size() > 0)
      chk(req, got.pop_front(), exp_q.pop_front());
    got.delete(); exp_q.delete();
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] r, w;
    void'($urandom(32'd4242));
    rst = 1; cfg_en = 0; hp_cs_n = 1; hp_rd_n = 1; hp_wr_n = 1; hp_addr = 0;
    hp_din = 0; dma_out_ready = 0; dma_in_valid = 0; dma_in_data = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);

    // R1 reset and disabled state
    chk("R1 ack", hp_ack, 0);
    chk("R1 irq", hp_irq, 0);
    chk("R1 out_valid", dma_out_valid, 0);
    chk("R1 in_ready", dma_in_ready, 0);
    hwrite(0, cw(1, 1, 1, 1));
    cfg_en = 1;
    repeat (3) @(negedge clk);
    hread(0, r);
    chk("R1 ctrl write ignored while disabled", r, st(0, 0, 1));
    chk("R8 ack dir0 empty", hp_ack, 1);

    // R2 R3 R4 16-bit little-endian
    hwrite(0, cw(0, 1, 0, 0));
    for (int i = 0; i < 3; i++) begin
      w = 16'h1100 + 16'(i * 16'h0123);
      hwrite(1, w); exp_q.push_back(w);
    end
    hread(0, r);
    chk("R2 status", r, st(cw(0, 1, 0, 0), 3, 0));
    hread(0, r);
    chk("R3 status read has no side effect", r, st(cw(0, 1, 0, 0), 3, 0));
    drain_cmp("R4 LE16");

    // R3 timing: action only after strobe ends
    @(negedge clk); hp_addr = 1; hp_din = 16'hBEEF; hp_cs_n = 0; hp_wr_n = 0;
    repeat (6) @(negedge clk);
    chk("R3 no push while strobe held", dma_out_valid, 0);
    hp_cs_n = 1; hp_wr_n = 1;
    repeat (6) @(negedge clk);
    chk("R3 push after strobe end", dma_out_valid, 1);
    exp_q.push_back(16'hBEEF);
    drain_cmp("R3 data");

    // R4 big-endian
    hwrite(0, cw(0, 1, 1, 0));
    hwrite(1, 16'hA1B2); exp_q.push_back(16'hB2A1);
    hwrite(1, 16'h0102); exp_q.push_back(16'h0201);
    drain_cmp("R4 BE16");

    // R5 8-bit packing
    hwrite(0, cw(0, 0, 0, 0));
    hwrite(1, 16'h0011);
    hread(0, r);
    chk("R5 lone byte not counted", r, st(cw(0, 0, 0, 0), 0, 1));
    hwrite(1, 16'h0022); exp_q.push_back(16'h2211);
    hwrite(1, 16'h0033); hwrite(1, 16'h0044); exp_q.push_back(16'h4433);
    drain_cmp("R5 LE8");
    hwrite(0, cw(0, 0, 1, 0));
    hwrite(1, 16'h00AA); hwrite(1, 16'h00BB); exp_q.push_back(16'hAABB);
    drain_cmp("R5 BE8");

    // R8 R11 full FIFO, ninth write dropped
    hwrite(0, cw(0, 1, 0, 0));
    for (int i = 0; i < 8; i++) begin
      w = 16'(32'h5000 + i); hwrite(1, w); exp_q.push_back(w);
    end
    chk("R8 ack low when full", hp_ack, 0);
    hread(0, r);
    chk("R11 count 8", r, st(cw(0, 1, 0, 0), 8, 0));
    hwrite(1, 16'hDEAD);
    drain_cmp("R8 R11 order and drop");
    chk("R8 ack back after drain", hp_ack, 1);

    // R9 interrupt mode, direction 0
    hwrite(0, cw(0, 1, 0, 1));
    chk("R9 irq empty dir0", hp_irq, 1);
    hwrite(1, 16'h7777); exp_q.push_back(16'h7777);
    chk("R9 irq drops with data", hp_irq, 0);
    chk("R9 ack held in irq mode", hp_ack, 1);
    drain_cmp("R9 data");
    chk("R9 irq back", hp_irq, 1);

    // R6 R8 device to host 16-bit
    hwrite(0, cw(1, 1, 0, 0));
    chk("R8 ack low dir1 empty", hp_ack, 0);
    push_in(16'hC0DE); push_in(16'h1234);
    repeat (3) @(negedge clk);
    chk("R8 ack dir1 data", hp_ack, 1);
    hread(1, r);
    chk("R6 LE16 read", r, 16'hC0DE);
    hwrite(0, cw(1, 1, 1, 0));
    hread(1, r);
    chk("R6 BE16 read", r, 16'h3412);
    hread(0, r);
    chk("R6 popped", r, st(cw(1, 1, 1, 0), 0, 0));

    // R7 8-bit reads
    hwrite(0, cw(1, 0, 0, 0));
    push_in(16'hABCD); push_in(16'h5566);
    hread(1, r); chk("R7 LE first byte", r, 16'h00CD);
    hread(1, r); chk("R7 LE second byte", r, 16'h00AB);
    hwrite(0, cw(1, 0, 1, 0));
    hread(1, r); chk("R7 BE first byte", r, 16'h0055);
    hread(1, r); chk("R7 BE second byte", r, 16'h0066);
    hread(0, r); chk("R7 popped both", r, st(cw(1, 0, 1, 0), 0, 0));

    // R9 interrupt mode, direction 1
    hwrite(0, cw(1, 1, 0, 1));
    for (int i = 0; i < 8; i++) push_in(16'(32'h9000 + i));
    repeat (3) @(negedge clk);
    chk("R9 irq full dir1", hp_irq, 1);
    chk("R11 in_ready low when full", dma_in_ready, 0);
    hread(1, r);
    chk("R9 first of burst", r, 16'h9000);
    chk("R9 irq drops after read", hp_irq, 0);

    // R10 direction change flushes
    hwrite(0, cw(0, 1, 0, 0));
    hread(0, r);
    chk("R10 flush on dir change", r, st(cw(0, 1, 0, 0), 0, 1));

    // R1 disable flushes
    hwrite(1, 16'h4321);
    cfg_en = 0;
    repeat (3) @(negedge clk);
    chk("R1 valid low when disabled", dma_out_valid, 0);
    chk("R1 ack low when disabled", hp_ack, 0);
    hwrite(1, 16'h9999);
    cfg_en = 1;
    repeat (3) @(negedge clk);
    chk("R1 write ignored while disabled", dma_out_valid, 0);

    // random bursts R4 R5 R11
    for (int it = 0; it < 20; it++) begin
      bit wide = 1'($urandom);
      bit big  = 1'($urandom);
      int n    = 1 + int'($urandom % 8);
      hwrite(0, cw(0, wide, big, 0));
      for (int k = 0; k < n; k++) begin
        w = 16'($urandom);
        if (wide) begin
          hwrite(1, w); exp_q.push_back(big ? sw(w) : w);
        end else begin
          hwrite(1, {8'h0, w[7:0]}); hwrite(1, {8'h0, w[15:8]});
          exp_q.push_back(big ? sw(w) : w);
        end
      end
      drain_cmp("R11 random burst");
    end

    summary();
    $finish;
  end
endmodule